// File: doc/BRIEF.md
# Split-Phase Programmable Clock Divider

This block derives a card-interface clock from a fast base clock (nominally 208 MHz). The division setting is one byte. Its upper nibble gives the length of the high phase and its lower nibble gives the length of the low phase, each stored as a count of base cycles minus one. The output period is therefore the high count plus the low count, not twice a single count. Setting 0x54 gives 6 + 5 = 11 base cycles, about 18.9 MHz. Setting 0x00 gives one cycle in each phase, 104 MHz, which is the fastest output.

A setting can be written at any time. The block holds it as pending and moves it into the active divider only when a low phase ends. The period in progress therefore always completes with its old phase lengths, and no shortened pulse appears on the output. Settings normally keep the two nibbles within one cycle of each other: 0x54, 0x44, 0x43, 0x33, 0x32, 0x22, 0x21, 0x11 and 0x00.

When the low-power input is high, the output follows a slower reference level (nominally 13 MHz), whatever setting is held. The divider keeps counting in the background, so the correct phase is available again when low power ends.

Top module: `nclk_divider`

## Requirements
- R1: After reset the output is high. The active setting is 0x54, so the first high run lasts 6 base cycles and the low run after it lasts 5.
- R2: Outside low power, each high run of clk_out lasts (wr_data[7:4] of the active setting) + 1 base cycles.
- R3: Outside low power, each low run of clk_out lasts (wr_data[3:0] of the active setting) + 1 base cycles.
- R4: Setting 0x00 makes the output alternate high and low on every base cycle.
- R5: A setting written while a period is running takes effect only at the next high phase after the current low phase ends. The period in progress keeps its old high and low lengths.
- R6: Only wr_data[7:0] is used; the bits above it have no effect on the output.
- R7: While lp_mode is high, clk_out equals the ref_in level of the previous base cycle, whatever setting is held.
- R8: A setting written while lp_mode is high is kept. It governs the output once lp_mode falls.
- R9: When several writes arrive before a period boundary, the last one written is the one applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock (nominally 208 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for a new divide setting |
| wr_data | input | DATA_W (16) | Write word; bits 7:4 set the high count minus one, bits 3:0 set the low count minus one |
| lp_mode | input | 1 | Low-power override: when high, the output follows ref_in |
| ref_in | input | 1 | Reference clock level (nominally 13 MHz), synchronous to clk |
| clk_out | output | 1 | Registered divided clock output |

## Verification
The checker checks four things on every cycle:
- each write lands in the pending setting;
- the active setting changes only on a low-to-high phase change;
- the phase counter never passes the limit of its current phase;
- the output tracks the reference with one cycle of delay while low power is on.

The actual run lengths can only be shown by the bench's scenarios. These cover the 11-cycle period after reset, asymmetric settings, the single-cycle setting, and ignored upper write bits. They also cover a period that finishes with its old lengths after a mid-period write, the last-write-wins case, and a setting written during low power that governs the output afterwards.

// File: rtl/nclk_div_pkg.sv
package nclk_div_pkg;
  // Phase encoding used by the phase generator
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // Select the limit for the current phase from a split setting
  function automatic logic [3:0] phase_limit(input logic [7:0] setting,
                                             input phase_e ph);
    return (ph == PH_HIGH) ? setting[7:4] : setting[3:0];
  endfunction
endpackage

// File: rtl/nclk_set_reg.sv
module nclk_set_reg #(
  parameter int SET_W     = 8,
  parameter int DATA_W    = 16,
  parameter logic [SET_W-1:0] RESET_SET = 8'h54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SET_W-1:0]  pend_set
);
  // Pending setting; only the low SET_W bits of the write are kept
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_set <= RESET_SET;
    end else if (wr_en) begin
      pend_set <= wr_data[SET_W-1:0];
    end
  end
endmodule

// File: rtl/nclk_phase_gen.sv
module nclk_phase_gen #(
  parameter int NIB_W = 4,
  parameter int SET_W = 2 * NIB_W,
  parameter logic [SET_W-1:0] RESET_SET = 8'h54
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] pend_set,
  output logic             phase_hi,
  output logic [NIB_W-1:0] cnt,
  output logic [SET_W-1:0] act_set
);
  logic [NIB_W-1:0] limit;
  logic             at_limit;

  assign limit    = phase_hi ? act_set[SET_W-1:NIB_W] : act_set[NIB_W-1:0];
  assign at_limit = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
      act_set  <= RESET_SET;
    end else if (at_limit) begin
      cnt      <= '0;
      phase_hi <= ~phase_hi;
      // Setting change only when a low phase closes the period
      if (!phase_hi) begin
        act_set <= pend_set;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nclk_out_sel.sv
module nclk_out_sel (
  input  logic clk,
  input  logic rst,
  input  logic lp_mode,
  input  logic ref_in,
  input  logic phase_hi,
  output logic clk_out
);
  // Registered output so the pin never carries combinational glitches
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out <= 1'b1;
    end else begin
      clk_out <= lp_mode ? ref_in : phase_hi;
    end
  end
endmodule

// File: rtl/nclk_divider.sv
module nclk_divider #(
  parameter int NIB_W  = 4,
  parameter int DATA_W = 16,
  parameter logic [2*NIB_W-1:0] RESET_SET = 8'h54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lp_mode,
  input  logic              ref_in,
  output logic              clk_out
);
  localparam int SET_W = 2 * NIB_W;

  logic [SET_W-1:0] pend_set;
  logic [SET_W-1:0] act_set;
  logic [NIB_W-1:0] cnt;
  logic             phase_hi;

  nclk_set_reg #(
    .SET_W(SET_W), .DATA_W(DATA_W), .RESET_SET(RESET_SET)
  ) set_reg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pend_set(pend_set)
  );

  nclk_phase_gen #(
    .NIB_W(NIB_W), .SET_W(SET_W), .RESET_SET(RESET_SET)
  ) phase_i (
    .clk(clk), .rst(rst), .pend_set(pend_set),
    .phase_hi(phase_hi), .cnt(cnt), .act_set(act_set)
  );

  nclk_out_sel out_i (
    .clk(clk), .rst(rst), .lp_mode(lp_mode), .ref_in(ref_in),
    .phase_hi(phase_hi), .clk_out(clk_out)
  );
endmodule

// File: rtl/nclk_divider_chk.sv
module nclk_divider_chk #(
  parameter int NIB_W  = 4,
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [DATA_W-1:0]    wr_data,
  input logic                 lp_mode,
  input logic                 ref_in,
  input logic                 clk_out,
  input logic                 phase_hi,
  input logic [NIB_W-1:0]     cnt,
  input logic [2*NIB_W-1:0]   act_set,
  input logic [2*NIB_W-1:0]   pend_set
);
  localparam int SET_W = 2 * NIB_W;

  assert_pend_load_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> pend_set == $past(wr_data[SET_W-1:0]));

  assert_act_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_set) |-> ($past(!phase_hi) && phase_hi));

  assert_hi_limit_R2: assert property (@(posedge clk) disable iff (rst)
    phase_hi |-> cnt <= act_set[SET_W-1:NIB_W]);

  assert_lo_limit_R3: assert property (@(posedge clk) disable iff (rst)
    !phase_hi |-> cnt <= act_set[NIB_W-1:0]);

  assert_lp_follow_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(lp_mode) && $past(!rst)) |-> clk_out == $past(ref_in));
endmodule

bind nclk_divider nclk_divider_chk #(.NIB_W(NIB_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .lp_mode(lp_mode), .ref_in(ref_in), .clk_out(clk_out),
  .phase_hi(phase_hi), .cnt(cnt), .act_set(act_set), .pend_set(pend_set)
);

// File: tb/nclk_divider_tb.sv
module nclk_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        lp_mode = 1'b0;
  logic        ref_in = 1'b0;
  logic        clk_out;

  int errors = 0;
  int checks = 0;
  logic s_cur = 1'b0;
  logic s_prev = 1'b0;

  always #2.5 clk = ~clk;

  nclk_divider dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .lp_mode(lp_mode), .ref_in(ref_in), .clk_out(clk_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one base cycle, sample output, drop any write strobe
  task automatic next_sample();
    @(negedge clk);
    wr_en  = 1'b0;
    s_prev = s_cur;
    s_cur  = clk_out;
  endtask

  task automatic run_len(output int n);
    logic lvl;
    lvl = s_cur;
    n = 1;
    forever begin
      next_sample();
      if (s_cur != lvl) break;
      n++;
    end
  endtask

  task automatic sync_rise();
    do next_sample(); while (!(s_prev == 1'b0 && s_cur == 1'b1));
  endtask

  task automatic put(input logic [15:0] d);
    wr_data = d;
    wr_en   = 1'b1;
  endtask

  task automatic expect_pair(input string req, input int hi, input int lo);
    int h, l;
    sync_rise();
    run_len(h);
    run_len(l);
    check(req, h, hi);
    check(req, l, lo);
  endtask

  task automatic t_reset();
    int h, l;
    @(negedge clk);
    check("R1 reset level", clk_out, 1);
    rst = 1'b0;
    s_cur = clk_out;
    run_len(h);
    h = h - 1; // first counted sample was taken while in reset
    run_len(l);
    check("R1 first high", h, 6);
    check("R1 first low", l, 5);
  endtask

  task automatic t_settings();
    put(16'h0043); next_sample();
    sync_rise(); // let the write reach a boundary
    expect_pair("R2 R3 0x43", 5, 4);
    put(16'h0021); next_sample();
    sync_rise();
    expect_pair("R2 R3 0x21", 3, 2);
  endtask

  task automatic t_fastest();
    int n;
    put(16'h0000); next_sample();
    sync_rise();
    sync_rise();
    for (int i = 0; i < 4; i++) begin
      run_len(n);
      check("R4 single cycle run", n, 1);
    end
  endtask

  task automatic t_upper_ignored();
    put(16'hAB33); next_sample();
    sync_rise();
    expect_pair("R6 upper bits ignored", 4, 4);
  endtask

  task automatic t_boundary();
    int h, l;
    put(16'h0054); next_sample();
    sync_rise(); sync_rise();
    // now at first high sample of a 0x54 period; write mid-period
    put(16'h0022);
    run_len(h);
    run_len(l);
    check("R5 old high kept", h, 6);
    check("R5 old low kept", l, 5);
    run_len(h);
    run_len(l);
    check("R5 new high", h, 3);
    check("R5 new low", l, 3);
  endtask

  task automatic t_last_wins();
    int h, l;
    sync_rise();
    put(16'h0011); next_sample();
    put(16'h0033);
    run_len(h);
    run_len(l);
    run_len(h);
    run_len(l);
    check("R9 last write high", h, 4);
    check("R9 last write low", l, 4);
  endtask

  task automatic t_low_power();
    int bad;
    bad = 0;
    lp_mode = 1'b1;
    put(16'h0032);
    for (int i = 0; i < 40; i++) begin
      ref_in = ((i / 8) % 2) != 0;
      next_sample();
      if (clk_out != ref_in) bad++;
    end
    check("R7 follows reference mismatches", bad, 0);
    lp_mode = 1'b0;
    ref_in  = 1'b0;
    sync_rise();
    expect_pair("R8 setting from low power", 4, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_settings();
    t_fastest();
    t_upper_ignored();
    t_boundary();
    t_last_wins();
    t_low_power();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule